// File: doc/BRIEF.md
# Extended Register Number Mapper

This block turns the short register fields found in a prefixed instruction's suffix word into extended register numbers for an enlarged register space. Each operand lane takes a 5-bit standard register field and a 3-bit extra field. It produces an extended register number and a flag that says whether the operand is a scalar or the base of a vector. The decoder uses one lane for the destination and up to three lanes for the sources.

Each lane has its own select between two register spaces. The integer/floating-point space has 128 entries and the condition-register-field space has 64 entries. In both spaces the extra bits are placed below the standard field as least significant bits. In the condition-register space the standard field is scaled by eight and the extra bits by two. The number is registered, so the result appears on the outputs one clock after the inputs are presented. Access to the register files is done elsewhere.

Top module: `ext_mapper`

## Requirements
- R1: While reset is asserted, every lane outputs number 0 with its vector flag at 0.
- R2: The outputs in a given cycle reflect the inputs that were sampled at the previous rising clock edge. The latency is exactly one cycle.
- R3: For a valid lane, the vector flag equals bit 2 of the extra field: 0 means scalar and 1 means vector.
- R4: For a valid lane with its condition-register select at 0, the number is field*4 + extra[1:0], in 7 bits. Example: field 5 with extra 001 gives 21.
- R5: For a valid lane with its condition-register select at 1, the number is field[2:0]*8 + extra[1:0]*2. Extra values 00, 01, 10 and 11 map to low bits 000, 010, 100 and 110. Bit 0 and bit 6 of the output are always 0. Example: field 6 with extra 001 gives 50.
- R6: In condition-register mode, field bits 4:3 have no effect on the result.
- R7: A lane whose valid input is 0 outputs number 0 with the vector flag at 0, whatever its other inputs are.
- R8: Lanes are independent. Lane i occupies bits [i*5 +: 5] of the field bus, [i*3 +: 3] of the extra bus and [i*7 +: 7] of the number bus. Lane 0 is the destination and lanes 1 to 3 are sources.
- R9: A standard register Rn with extra 000 maps to scalar extended register n*4. Example: R20 gives 80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 4 | Per-lane operand present |
| in_is_cr | input | 4 | Per-lane select: 1 for the condition-register-field space |
| in_field | input | 20 | Per-lane 5-bit standard register field |
| in_extra | input | 12 | Per-lane 3-bit extra field |
| out_num | output | 28 | Per-lane 7-bit extended register number |
| out_vec | output | 4 | Per-lane vector flag (0 = scalar) |

## Verification
The bench sweeps every field and extra value through both spaces at once, across four lanes. A design that put the extra bits above the field, or that scaled the condition-register space by four, would then produce wrong numbers at once. Dedicated cases put a condition-register field with its top bits set and an invalid lane carrying nonzero data. A mapper that leaks field bits 4:3 would give a number above 63. A lane that ignores its valid input would show a stale number or vector flag. Back-to-back inputs that differ each cycle expose any extra or missing pipeline stage, because the results then land one cycle off.

// File: rtl/ext_pkg.sv
package ext_pkg;
    localparam int DEF_NUM_OPS  = 4;
    localparam int DEF_FIELD_W  = 5;
    localparam int DEF_EXTRA_W  = 3;
    localparam int DEF_CR_SEL_W = 3;

    typedef enum logic [1:0] {
        ROLE_DEST = 2'd0,
        ROLE_SRC1 = 2'd1,
        ROLE_SRC2 = 2'd2,
        ROLE_SRC3 = 2'd3
    } op_role_e;
endpackage

// File: rtl/ext_gpr_calc.sv
module ext_gpr_calc #(
    parameter int FIELD_W = 5,
    parameter int LO_W    = 2,
    localparam int NUM_W  = FIELD_W + LO_W
) (
    input  logic [FIELD_W-1:0] field,
    input  logic [LO_W-1:0]    lo,
    output logic [NUM_W-1:0]   num
);
    // standard field forms the high part, extra bits fill the bottom
    assign num = {field, lo};
endmodule

// File: rtl/ext_cr_calc.sv
module ext_cr_calc #(
    parameter int SEL_W  = 3,
    parameter int LO_W   = 2,
    localparam int NUM_W = SEL_W + LO_W + 1
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [LO_W-1:0]  lo,
    output logic [NUM_W-1:0] num
);
    // CR suffix steps by two: only even sub-fields are reachable
    assign num = {sel, lo, 1'b0};
endmodule

// File: rtl/ext_lane.sv
module ext_lane #(
    parameter int FIELD_W  = 5,
    parameter int EXTRA_W  = 3,
    parameter int CR_SEL_W = 3,
    localparam int LO_W    = EXTRA_W - 1,
    localparam int INT_W   = FIELD_W + LO_W,
    localparam int CR_W    = CR_SEL_W + LO_W + 1,
    localparam int OUT_W   = (INT_W > CR_W) ? INT_W : CR_W
) (
    input  logic               valid,
    input  logic               is_cr,
    input  logic [FIELD_W-1:0] field,
    input  logic [EXTRA_W-1:0] extra,
    output logic [OUT_W-1:0]   num,
    output logic               vec
);
    logic [INT_W-1:0] gpr_num;
    logic [CR_W-1:0]  cr_num;

    ext_gpr_calc #(.FIELD_W(FIELD_W), .LO_W(LO_W)) u_gpr (
        .field (field),
        .lo    (extra[LO_W-1:0]),
        .num   (gpr_num)
    );

    ext_cr_calc #(.SEL_W(CR_SEL_W), .LO_W(LO_W)) u_cr (
        .sel   (field[CR_SEL_W-1:0]),
        .lo    (extra[LO_W-1:0]),
        .num   (cr_num)
    );

    always_comb begin
        num = '0;
        vec = 1'b0;
        if (valid) begin
            vec = extra[EXTRA_W-1];
            num = is_cr ? OUT_W'(cr_num) : OUT_W'(gpr_num);
        end
    end
endmodule

// File: rtl/ext_mapper.sv
module ext_mapper
    import ext_pkg::*;
#(
    parameter int NUM_OPS  = DEF_NUM_OPS,
    parameter int FIELD_W  = DEF_FIELD_W,
    parameter int EXTRA_W  = DEF_EXTRA_W,
    parameter int CR_SEL_W = DEF_CR_SEL_W,
    localparam int LO_W    = EXTRA_W - 1,
    localparam int INT_W   = FIELD_W + LO_W,
    localparam int CR_W    = CR_SEL_W + LO_W + 1,
    localparam int OUT_W   = (INT_W > CR_W) ? INT_W : CR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_OPS-1:0]         in_valid,
    input  logic [NUM_OPS-1:0]         in_is_cr,
    input  logic [NUM_OPS*FIELD_W-1:0] in_field,
    input  logic [NUM_OPS*EXTRA_W-1:0] in_extra,
    output logic [NUM_OPS*OUT_W-1:0]   out_num,
    output logic [NUM_OPS-1:0]         out_vec
);
    typedef struct packed {
        logic [OUT_W-1:0] num;
        logic             vec;
    } lane_t;

    typedef struct packed {
        lane_t [NUM_OPS-1:0] lane;
    } state_t;

    state_t state_d, state_q;

    logic [OUT_W-1:0]   lane_num [NUM_OPS];
    logic [NUM_OPS-1:0] lane_vec;

    // lane 0 = destination, lanes 1.. = sources (see op_role_e)
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_lane
        ext_lane #(
            .FIELD_W  (FIELD_W),
            .EXTRA_W  (EXTRA_W),
            .CR_SEL_W (CR_SEL_W)
        ) u_lane (
            .valid (in_valid[i]),
            .is_cr (in_is_cr[i]),
            .field (in_field[i*FIELD_W +: FIELD_W]),
            .extra (in_extra[i*EXTRA_W +: EXTRA_W]),
            .num   (lane_num[i]),
            .vec   (lane_vec[i])
        );

        assign out_num[i*OUT_W +: OUT_W] = state_q.lane[i].num;
        assign out_vec[i]                = state_q.lane[i].vec;
    end

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_OPS; i++) begin
            state_d.lane[i].num = lane_num[i];
            state_d.lane[i].vec = lane_vec[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/ext_mapper_chk.sv
module ext_mapper_chk #(
    parameter int NUM_OPS  = 4,
    parameter int FIELD_W  = 5,
    parameter int EXTRA_W  = 3,
    parameter int OUT_W    = 7,
    parameter int CR_SEL_W = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_OPS-1:0]         in_valid,
    input logic [NUM_OPS-1:0]         in_is_cr,
    input logic [NUM_OPS*FIELD_W-1:0] in_field,
    input logic [NUM_OPS*EXTRA_W-1:0] in_extra,
    input logic [NUM_OPS*OUT_W-1:0]   out_num,
    input logic [NUM_OPS-1:0]         out_vec
);
    logic started_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started_q <= 1'b0;
        else        started_q <= 1'b1;
    end

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_chk
        a_r7_idle_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (started_q && !$past(in_valid[i]))
            |-> (out_num[i*OUT_W +: OUT_W] == '0 && !out_vec[i]));

        a_r3_mode_follows_extra: assert property (@(posedge clk) disable iff (!rst_n)
            (started_q && $past(in_valid[i]))
            |-> (out_vec[i] == $past(in_extra[i*EXTRA_W + EXTRA_W - 1])));

        a_r4_gpr_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
            (started_q && $past(in_valid[i] && !in_is_cr[i]))
            |-> (out_num[i*OUT_W +: EXTRA_W-1] == $past(in_extra[i*EXTRA_W +: EXTRA_W-1])));

        a_r5_cr_even_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            (started_q && $past(in_valid[i] && in_is_cr[i]))
            |-> (!out_num[i*OUT_W] && !out_num[i*OUT_W + OUT_W - 1]));
    end
endmodule

bind ext_mapper ext_mapper_chk #(
    .NUM_OPS  (NUM_OPS),
    .FIELD_W  (FIELD_W),
    .EXTRA_W  (EXTRA_W),
    .OUT_W    (OUT_W),
    .CR_SEL_W (CR_SEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_is_cr (in_is_cr),
    .in_field (in_field),
    .in_extra (in_extra),
    .out_num  (out_num),
    .out_vec  (out_vec)
);

// File: tb/ext_mapper_test.sv
module ext_mapper_test;
    localparam int NOPS = 4;
    localparam int FW   = 5;
    localparam int EW   = 3;
    localparam int OW   = 7;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NOPS-1:0]      in_valid = '0;
    logic [NOPS-1:0]      in_is_cr = '0;
    logic [NOPS*FW-1:0]   in_field = '0;
    logic [NOPS*EW-1:0]   in_extra = '0;
    logic [NOPS*OW-1:0]   out_num;
    logic [NOPS-1:0]      out_vec;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ext_mapper uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_is_cr (in_is_cr),
        .in_field (in_field),
        .in_extra (in_extra),
        .out_num  (out_num),
        .out_vec  (out_vec)
    );

    typedef struct {
        logic [NOPS*OW-1:0] num;
        logic [NOPS-1:0]    vec;
        string              tag;
    } exp_t;

    exp_t sb[$];

    // expected values from the requirement arithmetic (R4, R5, R3, R7)
    function automatic exp_t model(input logic [NOPS-1:0] v, input logic [NOPS-1:0] c,
                                   input logic [NOPS*FW-1:0] f, input logic [NOPS*EW-1:0] e,
                                   input string tag);
        exp_t x;
        x.num = '0;
        x.vec = '0;
        x.tag = tag;
        for (int i = 0; i < NOPS; i++) begin
            int fv, ev, n;
            fv = int'(f[i*FW +: FW]);
            ev = int'(e[i*EW +: EW]);
            if (v[i]) begin
                x.vec[i] = (ev >= 4);
                if (c[i]) n = (fv % 8) * 8 + (ev % 4) * 2;
                else      n = fv * 4 + (ev % 4);
                x.num[i*OW +: OW] = OW'(n);
            end
        end
        return x;
    endfunction

    task automatic send(input logic [NOPS-1:0] v, input logic [NOPS-1:0] c,
                        input logic [NOPS*FW-1:0] f, input logic [NOPS*EW-1:0] e,
                        input string tag);
        @(negedge clk);
        in_valid = v;
        in_is_cr = c;
        in_field = f;
        in_extra = e;
        sb.push_back(model(v, c, f, e, tag));
    endtask

    task automatic check_now(input string tag, input logic [NOPS*OW-1:0] en,
                             input logic [NOPS-1:0] ev);
        total++;
        if (out_num !== en || out_vec !== ev) begin
            bad++;
            $display("FAIL %s: num=%h vec=%b expected num=%h vec=%b",
                     tag, out_num, out_vec, en, ev);
        end
    endtask

    // monitor: results of a push at negedge k appear after posedge k+1
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                check_now(x.tag, x.num, x.vec);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs held at zero under reset, even with live inputs
        in_valid = '1;
        in_extra = '1;
        in_field = '1;
        repeat (3) @(posedge clk);
        #2;
        check_now("R1 reset", '0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = '0;

        // R4 R8: lane layout, SVR5_01 -> 21 on lane 0
        send(4'b0001, 4'b0000, {15'd0, 5'd5}, {9'd0, 3'b001}, "R4 lane0 field5 extra001");
        // R9: R20 aliases 80, scalar, on each lane position
        send(4'b1111, 4'b0000, {4{5'd20}}, {4{3'b000}}, "R9 alias r20");
        // R3: vector mode with top value
        send(4'b0100, 4'b0000, {5'd0, 5'd31, 10'd0}, {3'd0, 3'b111, 6'd0}, "R3 vector top");
        // R5: CR field 6, extra 001 -> 50; lane 1 extra 000 -> 48
        send(4'b0011, 4'b0011, {10'd0, 5'd6, 5'd6}, {6'd0, 3'b000, 3'b001}, "R5 cr field6");
        // R5: CR top corner, vector
        send(4'b1000, 4'b1000, {5'd7, 15'd0}, {3'b111, 9'd0}, "R5 cr top vector");
        // R6: field bits 4:3 set in CR mode ignored (30 -> sel 6, extra 011 -> 54)
        send(4'b0001, 4'b0001, {15'd0, 5'd30}, {9'd0, 3'b011}, "R6 cr high bits");
        // R7: invalid lanes with data present give zero
        send(4'b0101, 4'b0100, {5'd31, 5'd12, 5'd31, 5'd9}, {3'b111, 3'b110, 3'b111, 3'b101},
             "R7 idle lanes");
        // R8: mixed spaces in one cycle
        send(4'b1111, 4'b1010, {5'd3, 5'd17, 5'd1, 5'd25}, {3'b110, 3'b010, 3'b101, 3'b011},
             "R8 mixed lanes");
        // R2: idle cycle between, then back-to-back differing items
        @(negedge clk);
        in_valid = '0;
        @(negedge clk);
        send(4'b0001, 4'b0000, {15'd0, 5'd1}, {9'd0, 3'b001}, "R2 b2b first");
        send(4'b0001, 4'b0000, {15'd0, 5'd2}, {9'd0, 3'b110}, "R2 b2b second");
        send(4'b0000, 4'b0000, {15'd0, 5'd2}, {9'd0, 3'b110}, "R2 b2b idle");

        // R4 R5 sweep over every field/extra combination
        for (int f = 0; f < 32; f++) begin
            for (int e = 0; e < 8; e++) begin
                send(4'b0111, 4'b0010,
                     {5'(f), 5'(31 - f), 5'(f), 5'(f)},
                     {3'(e), 3'(7 - e), 3'(e), 3'(e)},
                     "R4 R5 sweep");
            end
        end

        @(negedge clk);
        in_valid = '0;
        repeat (3) @(posedge clk);
        #3;
        if (sb.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R2 scoreboard: left=%0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule